// File: doc/BRIEF.md
# Serial receive channel

This block is one receive path of a dual-channel asynchronous serial controller. It watches a serial line and a receive sample strobe. The strobe runs at one of four selectable rates: once per bit, or 16, 32 or 64 times per bit. From this input the block recovers characters of five to eight data bits with an optional parity bit. Every completed character is placed in a one-entry holding register. The register carries a valid flag and per-character parity and framing error flags. An overrun flag and a line-break indication are also provided.

Reception is opened by an enable input. An optional carrier gate can also hold reception off while the carrier-detect input is high. In the oversampled rates, a falling line is treated only as a candidate start bit. It counts as a start bit only if the line is still low half a bit period later, and each later bit is sampled once, at its centre. At the once-per-bit rate there is no start check, and the outside world keeps the strobe aligned with the bits. The strobe `samp_tick` is a one-cycle enable in the `clk` domain. The line `ser_in` is already synchronous to `clk`.

Top module: `sio_rx_channel`

## Requirements
- R1: While `rcv_enable` is low, no character is ever received, whatever the line does.
- R2: When `carrier_gate` is 1, a new character can begin only while `carrier_n` is 0. When `carrier_gate` is 0, `carrier_n` is ignored.
- R3: With `clk_mode` 01, 10 or 11 (16, 32 or 64 strobes per bit), the first low strobe sample marks a candidate start. The start is accepted only if the line is still low on the strobe that falls div/2 strobes later. A line high on any strobe in between sends the receiver back to hunting, and no character results.
- R4: After an accepted start, each data bit is sampled once, `div` strobes after the previous sample point. This places every sample at mid-bit. The first bit on the line lands in `rx_data` bit 0.
- R5: With `clk_mode` 00, the first low sample is the start bit, and each following strobe samples one further bit.
- R6: `char_len` sets the number of data bits to 5 plus its value (00 gives 5, 11 gives 8). The unused upper bits of `rx_data` read as 1.
- R7: `par_mode` bit 0 enables a parity bit that follows the data bits. `par_mode` bit 1 selects even (1) or odd (0) parity. `par_err` is set when the received parity does not match, and it is always 0 when parity is off.
- R8: `frm_err` is set for a character whose stop-bit sample is low.
- R9: A character received with all zeros, parity and stop bit included, raises `line_break` together with `frm_err`. No further character is assembled until the line is sampled high, and that sample clears `line_break`.
- R10: A completed character appears in `rx_data` with `rx_valid` = 1 on the clock after its stop sample. A one-cycle `rd_ack` clears `rx_valid`. After reset, `rx_valid`, `ovr_err` and `line_break` are 0.
- R11: If a character completes while `rx_valid` is 1 and no `rd_ack` arrives in the same cycle, `ovr_err` is set and the newer character replaces the older. `rd_ack` clears `ovr_err`.
- R12: Dropping `rcv_enable` returns the receiver to hunting at once and discards any partly assembled character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_tick | input | 1 | Receive sample strobe, one clock wide |
| ser_in | input | 1 | Serial data line, high when idle |
| rcv_enable | input | 1 | Receiver enable |
| carrier_gate | input | 1 | When 1, a start requires `carrier_n` low |
| carrier_n | input | 1 | Carrier detect, active low |
| clk_mode | input | 2 | Strobes per bit: 00=1, 01=16, 10=32, 11=64 |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | Bit 0 parity on, bit 1 even |
| rd_ack | input | 1 | Holding register read strobe |
| rx_data | output | 8 | Received character, padded with 1s |
| rx_valid | output | 1 | Holding register full |
| par_err | output | 1 | Parity error of the held character |
| frm_err | output | 1 | Framing error of the held character |
| ovr_err | output | 1 | Character lost by overwrite |
| line_break | output | 1 | Break condition on the line |

## Verification
Two situations cannot be seen directly at the ports. One is a start pulse that is rejected. The other is a partial character thrown away when the enable drops. In both cases the visible effect is only that no character appears. The stimulus drives the line one strobe at a time. It holds the line low for exactly div/2 samples, then high, so the pulse stops one sample short of acceptance. For the enable case, the bench cuts the enable in the middle of a frame. In both tests the line then idles high for longer than a whole frame, so a receiver that wrongly kept running would finish a spurious character. The bench checks for that character before sending a clean frame and comparing it against the expected value.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;
  localparam int IDX_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_BRK} rx_state_e;

  // strobes per bit for each clock mode code
  function automatic logic [CNT_W-1:0] ticks_per_bit(input logic [1:0] mode);
    case (mode)
      2'd0:    return 7'd1;
      2'd1:    return 7'd16;
      2'd2:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] data_bits(input logic [1:0] len_code);
    return 4'd5 + {2'b00, len_code};
  endfunction

  // data bits + optional parity + one stop bit
  function automatic logic [IDX_W-1:0] frame_bits(input logic [1:0] len_code,
                                                  input logic [1:0] pmode);
    return data_bits(len_code) + {3'b000, pmode[0]} + 4'd1;
  endfunction

  function automatic logic [DATA_W-1:0] upper_mask(input logic [1:0] len_code);
    return 8'hFF << data_bits(len_code);
  endfunction

  function automatic logic [DATA_W-1:0] pad_char(input logic [DATA_W-1:0] raw,
                                                 input logic [1:0] len_code);
    return (raw & ~upper_mask(len_code)) | upper_mask(len_code);
  endfunction

  function automatic logic par_bad(input logic [DATA_W-1:0] raw,
                                   input logic [1:0] len_code,
                                   input logic pbit,
                                   input logic [1:0] pmode);
    logic ones;
    ones = (^(raw & ~upper_mask(len_code))) ^ pbit;
    if (!pmode[0]) return 1'b0;
    return pmode[1] ? ones : ~ones;
  endfunction

endpackage

// File: rtl/sio_rx_gate.sv
module sio_rx_gate (
  input  logic rcv_enable,
  input  logic carrier_gate,
  input  logic carrier_n,
  output logic hunt_ok
);
  // a new start may be hunted only while enabled and, if gated, carrier present
  assign hunt_ok = rcv_enable & (~carrier_gate | ~carrier_n);
endmodule

// File: rtl/sio_rx_sampler.sv
module sio_rx_sampler
  import sio_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_tick,
  input  logic             ser_in,
  input  logic             rcv_enable,
  input  logic             hunt_ok,
  input  logic [1:0]       clk_mode,
  input  logic [1:0]       char_len,
  input  logic [1:0]       par_mode,
  input  logic             brk_hit,
  output logic             take,
  output logic             take_val,
  output logic [IDX_W-1:0] take_idx,
  output logic             frame_end,
  output rx_state_e        st_o
);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] div;
  logic [CNT_W-1:0] half;
  logic             x1_mode;
  logic [IDX_W-1:0] nbits;

  // named internal events
  logic start_seen, start_ok;

  assign div     = ticks_per_bit(clk_mode);
  assign half    = div >> 1;
  assign x1_mode = (clk_mode == 2'd0);
  assign nbits   = frame_bits(char_len, par_mode);

  assign start_seen = (st == ST_IDLE) && samp_tick && hunt_ok && !ser_in;
  assign start_ok   = (st == ST_START) && samp_tick && !ser_in && (cnt == half - 7'd1);

  assign take      = (st == ST_DATA) && samp_tick && (cnt == div - 7'd1);
  assign take_val  = ser_in;
  assign take_idx  = idx;
  assign frame_end = take && (idx == nbits - 4'd1);
  assign st_o      = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      idx <= '0;
    end else if (!rcv_enable) begin
      st  <= ST_IDLE;
      cnt <= '0;
      idx <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_seen) begin
            st  <= x1_mode ? ST_DATA : ST_START;
            cnt <= '0;
            idx <= '0;
          end
        end
        ST_START: begin
          if (samp_tick) begin
            if (ser_in) begin
              st <= ST_IDLE;
            end else if (start_ok) begin
              st  <= ST_DATA;
              cnt <= '0;
            end else begin
              cnt <= cnt + 7'd1;
            end
          end
        end
        ST_DATA: begin
          if (samp_tick) begin
            if (take) begin
              cnt <= '0;
              if (frame_end) st <= brk_hit ? ST_BRK : ST_IDLE;
              else           idx <= idx + 4'd1;
            end else begin
              cnt <= cnt + 7'd1;
            end
          end
        end
        ST_BRK: begin
          if (samp_tick && ser_in) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_disable_idles_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rcv_enable |=> (st == ST_IDLE));

  assert_no_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !hunt_ok) |=> (st == ST_IDLE));

  assert_short_start_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && samp_tick && ser_in && rcv_enable) |=> (st == ST_IDLE));

  assert_x1_no_validation_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && x1_mode) |=> (st != ST_START));

endmodule

// File: rtl/sio_rx_assembler.sv
module sio_rx_assembler
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_val,
  input  logic [IDX_W-1:0]  take_idx,
  input  logic              frame_end,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              brk_hit
);

  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic [IDX_W-1:0]  nd;

  assign nd = data_bits(char_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (take && !frame_end) begin
      if (take_idx < nd) shreg[take_idx[2:0]] <= take_val;
      else               pbit <= take_val;
    end
  end

  assign char_done = frame_end;
  assign char_data = pad_char(shreg, char_len);
  assign char_perr = par_bad(shreg, char_len, pbit, par_mode);
  assign char_ferr = !take_val;
  assign brk_hit   = frame_end && !take_val
                     && ((shreg & ~upper_mask(char_len)) == '0)
                     && (!par_mode[0] || !pbit);

  assert_take_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_idx < frame_bits(char_len, par_mode)));

endmodule

// File: rtl/sio_rx_holding.sv
module sio_rx_holding
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
    end else if (char_done) begin
      rx_data  <= char_data;
      rx_valid <= 1'b1;
      par_err  <= char_perr;
      frm_err  <= char_ferr;
      ovr_err  <= (ovr_err | rx_valid) & ~rd_ack;
    end else if (rd_ack) begin
      rx_valid <= 1'b0;
      ovr_err  <= 1'b0;
    end
  end

  assert_done_sets_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_valid);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !char_done) |=> (!rx_valid && !ovr_err));

  assert_overrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_valid && !rd_ack) |=> ovr_err);

endmodule

// File: rtl/sio_rx_channel.sv
module sio_rx_channel
  import sio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              ser_in,
  input  logic              rcv_enable,
  input  logic              carrier_gate,
  input  logic              carrier_n,
  input  logic [1:0]        clk_mode,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              line_break
);

  logic              hunt_ok;
  logic              take, take_val, frame_end, brk_hit;
  logic [IDX_W-1:0]  take_idx;
  rx_state_e         st;
  logic              char_done, char_perr, char_ferr;
  logic [DATA_W-1:0] char_data;

  sio_rx_gate u_gate (
    .rcv_enable   (rcv_enable),
    .carrier_gate (carrier_gate),
    .carrier_n    (carrier_n),
    .hunt_ok      (hunt_ok)
  );

  sio_rx_sampler u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_tick  (samp_tick),
    .ser_in     (ser_in),
    .rcv_enable (rcv_enable),
    .hunt_ok    (hunt_ok),
    .clk_mode   (clk_mode),
    .char_len   (char_len),
    .par_mode   (par_mode),
    .brk_hit    (brk_hit),
    .take       (take),
    .take_val   (take_val),
    .take_idx   (take_idx),
    .frame_end  (frame_end),
    .st_o       (st)
  );

  sio_rx_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_val  (take_val),
    .take_idx  (take_idx),
    .frame_end (frame_end),
    .char_len  (char_len),
    .par_mode  (par_mode),
    .char_done (char_done),
    .char_data (char_data),
    .char_perr (char_perr),
    .char_ferr (char_ferr),
    .brk_hit   (brk_hit)
  );

  sio_rx_holding u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_done (char_done),
    .char_data (char_data),
    .char_perr (char_perr),
    .char_ferr (char_ferr),
    .rd_ack    (rd_ack),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err)
  );

  assign line_break = (st == ST_BRK);

  assert_carrier_holds_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && carrier_gate && carrier_n) |=> (st == ST_IDLE));

  assert_break_with_framing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_break) |-> frm_err);

endmodule

// File: tb/sio_rx_channel_bench.sv
module sio_rx_channel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_tick = 1'b0;
  logic       ser_in = 1'b1;
  logic       rcv_enable = 1'b0;
  logic       carrier_gate = 1'b0;
  logic       carrier_n = 1'b1;
  logic [1:0] clk_mode = 2'd1;
  logic [1:0] char_len = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err, ovr_err, line_break;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sio_rx_channel u_sio_rx_channel (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .ser_in(ser_in),
    .rcv_enable(rcv_enable), .carrier_gate(carrier_gate), .carrier_n(carrier_n),
    .clk_mode(clk_mode), .char_len(char_len), .par_mode(par_mode), .rd_ack(rd_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
    .ovr_err(ovr_err), .line_break(line_break)
  );

  function automatic int div_of(input logic [1:0] m);
    if (m == 2'd0) return 1;
    return 8 << m;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input logic [1:0] lc);
    logic [7:0] hi;
    hi = 8'hFF << (5 + lc);
    return (d & ~hi) | hi;
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] lc,
                                   input logic [1:0] pm);
    logic [7:0] lo;
    lo = ~(8'hFF << (5 + lc));
    return pm[1] ? ^(d & lo) : ~(^(d & lo));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) samp_tick = 1'b1;
    @(negedge clk) samp_tick = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    ser_in = v;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ack();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop);
    int n;
    logic pb;
    n = div_of(clk_mode);
    hold(1'b0, n);
    for (int i = 0; i < 5 + int'(char_len); i++) hold(d[i], n);
    if (par_mode[0]) begin
      pb = par_bit(d, char_len, par_mode) ^ bad_par;
      hold(pb, n);
    end
    hold(stop, n);
  endtask

  task automatic frame_check(input string tag, input logic [7:0] d,
                             input logic bad_par, input logic stop);
    send(d, bad_par, stop);
    hold(1'b1, 2);
    check({tag, " valid"}, rx_valid, 1);
    check({tag, " data"}, rx_data, exp_byte(d, char_len));
    check({tag, " par_err"}, par_err, bad_par & par_mode[0]);
    check({tag, " frm_err"}, frm_err, !stop);
    ack();
    check({tag, " cleared"}, rx_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset valid", rx_valid, 0);
    check("R10 reset ovr", ovr_err, 0);
    check("R10 reset break", line_break, 0);

    // R1: disabled receiver ignores a full frame
    clk_mode = 2'd1; char_len = 2'd3; par_mode = 2'd0;
    send(8'h3C, 1'b0, 1'b1);
    hold(1'b1, 4);
    check("R1 disabled no char", rx_valid, 0);

    rcv_enable = 1'b1;
    hold(1'b1, 4);
    frame_check("R4 x16 8N", 8'hA5, 1'b0, 1'b1);

    clk_mode = 2'd0; par_mode = 2'b11;
    frame_check("R5 x1 8E", 8'h3C, 1'b0, 1'b1);

    clk_mode = 2'd2; char_len = 2'd0; par_mode = 2'd0;
    frame_check("R6 x32 len5 pad", 8'h1B, 1'b0, 1'b1);

    clk_mode = 2'd1; char_len = 2'd2; par_mode = 2'b01;
    frame_check("R7 odd bad", 8'h45, 1'b1, 1'b1);
    frame_check("R7 odd good", 8'h45, 1'b0, 1'b1);

    char_len = 2'd3; par_mode = 2'd0;
    frame_check("R8 framing", 8'h55, 1'b0, 1'b0);
    check("R8 not break", line_break, 0);

    // R3: low for exactly div/2 samples then high must be rejected
    hold(1'b0, 8);
    hold(1'b1, 200);
    check("R3 glitch dropped", rx_valid, 0);
    frame_check("R3 after glitch", 8'h96, 1'b0, 1'b1);
    clk_mode = 2'd3;
    hold(1'b0, 32);
    hold(1'b1, 800);
    check("R3 x64 glitch dropped", rx_valid, 0);
    clk_mode = 2'd1;

    // R9: break
    send(8'h00, 1'b0, 1'b0);
    hold(1'b0, 2);
    check("R9 break flag", line_break, 1);
    check("R9 break framing", frm_err, 1);
    check("R9 break data", rx_data, 8'h00);
    ack();
    hold(1'b0, 60);
    check("R9 no char in break", rx_valid, 0);
    check("R9 break held", line_break, 1);
    hold(1'b1, 1);
    @(negedge clk);
    check("R9 break cleared", line_break, 0);
    hold(1'b1, 4);

    // R11: overrun
    send(8'h11, 1'b0, 1'b1);
    hold(1'b1, 2);
    check("R11 no ovr single", ovr_err, 0);
    send(8'h22, 1'b0, 1'b1);
    hold(1'b1, 2);
    check("R11 ovr set", ovr_err, 1);
    check("R11 newer kept", rx_data, 8'h22);
    ack();
    check("R11 ovr cleared", ovr_err, 0);
    check("R10 valid cleared", rx_valid, 0);

    // R12: disable mid-frame discards partial character
    hold(1'b0, 16);
    hold(1'b0, 48);
    @(negedge clk) rcv_enable = 1'b0;
    tick(); tick();
    @(negedge clk) rcv_enable = 1'b1;
    hold(1'b1, 200);
    check("R12 partial discarded", rx_valid, 0);
    frame_check("R12 clean after", 8'hC3, 1'b0, 1'b1);

    // R2: carrier gate
    carrier_gate = 1'b1; carrier_n = 1'b1;
    send(8'h7E, 1'b0, 1'b1);
    hold(1'b1, 4);
    check("R2 no carrier no char", rx_valid, 0);
    carrier_n = 1'b0;
    frame_check("R2 carrier present", 8'h81, 1'b0, 1'b1);
    carrier_gate = 1'b0; carrier_n = 1'b1;
    frame_check("R2 gate off", 8'h24, 1'b0, 1'b1);

    // random frames
    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      logic bp, sb;
      clk_mode = 2'($urandom_range(0, 3));
      char_len = 2'($urandom_range(0, 3));
      par_mode = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      bp = par_mode[0] && ($urandom_range(0, 3) == 0);
      sb = ($urandom_range(0, 4) != 0);
      if (!sb) d[0] = 1'b1;
      hold(1'b1, 2);
      frame_check("R4 R6 R7 random", d, bp, sb);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule